// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches a sliced, active-low composite sync level and finds the vertical sync interval. It measures how long sync has stayed low within the current pulse. Broad vertical pulses run far longer than horizontal, equalizing or serration pulses, so a low time above a programmable threshold marks vertical sync. When that happens the block raises its vertical sync output. In the same clock it sets the field parity from the horizontal position at which detection occurred. A detection before the half-line position gives an odd field. A detection at or after it gives an even field.

The block also runs without detections. A line counter toggles the field output on its own when no detection arrives for a full field of lines (263 lines or 313 lines, chosen by a standard-select input). A window supervisor groups line strobes into windows of 337 lines, counted from reset. It declares vertical sync lost after one, or three, consecutive windows with no detection. When it declares the loss it raises a one-clock request to put the phase-locked loops back into acquisition. Sync slicing and the loops themselves are outside this block.

Top module: `vsfd_top`

## Requirements
- R1: The low-time count rises by one on each clock edge at which `sync_n` is sampled low, and clears on any edge at which it is sampled high. `vsync` rises on the edge after the one at which the count first exceeds `vthresh`. With `vthresh`=10, a low run of 11 samples asserts `vsync`.
- R2: A low run whose length does not exceed `vthresh` (10 samples at `vthresh`=10, or the 3-sample horizontal pulses) never asserts `vsync`.
- R3: On the edge where `vsync` rises, `field` takes the value 0 (odd) if `hpos` sampled at that edge is below `half_pos`, and 1 (even) otherwise.
- R4: After it rises, `vsync` stays high until the third `line_stb` has been sampled, and falls on that edge.
- R5: After a detection, no new detection occurs until `vsync` is low and the low-time count has been at or below `vthresh` for at least one edge. Broad pulses inside the held interval therefore give a single rising edge of `vsync`.
- R6: With no detection, `field` inverts on the 263rd `line_stb` after the last detection or inversion when `std625`=0, and on the 313th when `std625`=1.
- R7: Line strobes form windows of 337 strobes counted from reset. At the end of a window with no detection, a miss is counted. `vs_lost` sets at that window end once the consecutive misses reach 1 (`tol3`=0) or 3 (`tol3`=1).
- R8: `pll_reacq` is high for exactly one clock, on the edge where `vs_lost` rises, and at no other time.
- R9: A detection clears `vs_lost` and the miss count on the same edge that `vsync` rises.
- R10: While `rst` is sampled high, all outputs are 0 on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Sliced composite sync level, low during sync |
| line_stb | input | 1 | One-clock strobe at the start of each line |
| hpos | input | HW | Current horizontal position within the line |
| vthresh | input | CW | Low-time count above which vertical sync is detected |
| half_pos | input | HW | Horizontal position that separates the two line halves |
| tol3 | input | 1 | 0: declare loss after 1 missing window; 1: after 3 |
| std625 | input | 1 | 0: free-run field of 263 lines; 1: of 313 lines |
| vsync | output | 1 | Vertical sync indication |
| field | output | 1 | Field parity, 0 odd, 1 even |
| vs_lost | output | 1 | Vertical sync lost flag |
| pll_reacq | output | 1 | One-clock request to restart loop acquisition |

## Verification
The low-time count takes one register stage and detection another, so `vsync` and `field` are due on the second edge after the low sample that takes the count past the threshold. A line strobe acts on the edge that samples it, so a `vsync` fall, a free-run toggle, a window end, a `vs_lost` set and the `pll_reacq` pulse all appear one edge after the strobe is driven. The bench keeps a behavioural model that advances on the same posedge from the same inputs, and compares every output at the following negedge. Event counts (rises, toggles, pulses) are checked at line boundaries.

// File: rtl/vsfd_pkg.sv
package vsfd_pkg;
  localparam int DEF_HOLD_LINES = 3;
  localparam int DEF_WIN_LINES  = 337;
  localparam int DEF_FR_525     = 263;
  localparam int DEF_FR_625     = 313;

  typedef enum logic {
    PAR_ODD  = 1'b0,
    PAR_EVEN = 1'b1
  } parity_e;

  function automatic logic [1:0] sat_inc2(input logic [1:0] v);
    return (v == 2'b11) ? v : v + 2'd1;
  endfunction
endpackage

// File: rtl/vsfd_lowtime.sv
module vsfd_lowtime #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_n,
  input  logic [CW-1:0] vthresh,
  output logic          exceed
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= '0;
    end else if (sync_n) begin
      low_q <= '0;
    end else if (low_q != CMAX) begin
      low_q <= low_q + 1'b1;
    end
  end

  assign exceed = (low_q > vthresh);
endmodule

// File: rtl/vsfd_vfield.sv
module vsfd_vfield
  import vsfd_pkg::*;
#(
  parameter int HW         = 10,
  parameter int HOLD_LINES = DEF_HOLD_LINES,
  parameter int FR_A       = DEF_FR_525,
  parameter int FR_B       = DEF_FR_625
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exceed,
  input  logic          line_stb,
  input  logic [HW-1:0] hpos,
  input  logic [HW-1:0] half_pos,
  input  logic          std625,
  output logic          det,
  output logic          vsync,
  output logic          field
);
  localparam int FR_MAX = (FR_A > FR_B) ? FR_A : FR_B;
  localparam int LW     = $clog2(FR_MAX + 1);
  localparam int HLW    = $clog2(HOLD_LINES + 1);
  localparam logic [LW-1:0]  LAST_A    = LW'(FR_A - 1);
  localparam logic [LW-1:0]  LAST_B    = LW'(FR_B - 1);
  localparam logic [HLW-1:0] HOLD_LAST = HLW'(HOLD_LINES - 1);

  logic           armed_q;
  logic [HLW-1:0] hold_q;
  logic [LW-1:0]  lines_q;
  logic [LW-1:0]  last_line;
  parity_e        par_now;

  assign det       = armed_q & exceed;
  assign last_line = std625 ? LAST_B : LAST_A;
  assign par_now   = (hpos >= half_pos) ? PAR_EVEN : PAR_ODD;

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync   <= 1'b0;
      field   <= PAR_ODD;
      armed_q <= 1'b1;
      hold_q  <= '0;
      lines_q <= '0;
    end else if (det) begin
      vsync   <= 1'b1;
      field   <= par_now;
      armed_q <= 1'b0;
      hold_q  <= '0;
      lines_q <= '0;
    end else begin
      if (vsync && line_stb) begin
        if (hold_q == HOLD_LAST) begin
          vsync <= 1'b0;
        end else begin
          hold_q <= hold_q + 1'b1;
        end
      end
      if (!vsync && !exceed) begin
        armed_q <= 1'b1;
      end
      if (line_stb) begin
        if (lines_q >= last_line) begin
          lines_q <= '0;
          field   <= ~field;
        end else begin
          lines_q <= lines_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vsfd_lossmon.sv
module vsfd_lossmon
  import vsfd_pkg::*;
#(
  parameter int WIN_LINES = DEF_WIN_LINES
) (
  input  logic clk,
  input  logic rst,
  input  logic det,
  input  logic line_stb,
  input  logic tol3,
  output logic lost,
  output logic reacq
);
  localparam int WW = $clog2(WIN_LINES + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LINES - 1);

  logic [WW-1:0] win_q;
  logic          seen_q;
  logic [1:0]    miss_q;
  logic [1:0]    miss_nx;
  logic [1:0]    need;
  logic          win_end;
  logic          win_miss;
  logic          declare;

  assign win_end  = line_stb && (win_q == WIN_LAST);
  assign win_miss = win_end && !seen_q && !det;
  assign miss_nx  = sat_inc2(miss_q);
  assign need     = tol3 ? 2'd3 : 2'd1;
  assign declare  = win_miss && (miss_nx >= need);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      seen_q <= 1'b0;
      miss_q <= '0;
      lost   <= 1'b0;
      reacq  <= 1'b0;
    end else begin
      reacq <= declare && !lost;
      if (line_stb) begin
        win_q <= win_end ? '0 : win_q + 1'b1;
      end
      if (win_end) begin
        seen_q <= 1'b0;
      end else if (det) begin
        seen_q <= 1'b1;
      end
      if (det) begin
        miss_q <= '0;
        lost   <= 1'b0;
      end else if (win_miss) begin
        miss_q <= miss_nx;
        if (declare) begin
          lost <= 1'b1;
        end
      end else if (win_end) begin
        miss_q <= '0;
      end
    end
  end
endmodule

// File: rtl/vsfd_top.sv
module vsfd_top
  import vsfd_pkg::*;
#(
  parameter int HW         = 10,
  parameter int CW         = 10,
  parameter int HOLD_LINES = DEF_HOLD_LINES,
  parameter int WIN_LINES  = DEF_WIN_LINES,
  parameter int FR_A       = DEF_FR_525,
  parameter int FR_B       = DEF_FR_625
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_n,
  input  logic          line_stb,
  input  logic [HW-1:0] hpos,
  input  logic [CW-1:0] vthresh,
  input  logic [HW-1:0] half_pos,
  input  logic          tol3,
  input  logic          std625,
  output logic          vsync,
  output logic          field,
  output logic          vs_lost,
  output logic          pll_reacq
);
  logic exceed;
  logic det;

  vsfd_lowtime #(.CW(CW)) u_low (
    .clk     (clk),
    .rst     (rst),
    .sync_n  (sync_n),
    .vthresh (vthresh),
    .exceed  (exceed)
  );

  vsfd_vfield #(
    .HW(HW), .HOLD_LINES(HOLD_LINES), .FR_A(FR_A), .FR_B(FR_B)
  ) u_fld (
    .clk      (clk),
    .rst      (rst),
    .exceed   (exceed),
    .line_stb (line_stb),
    .hpos     (hpos),
    .half_pos (half_pos),
    .std625   (std625),
    .det      (det),
    .vsync    (vsync),
    .field    (field)
  );

  vsfd_lossmon #(.WIN_LINES(WIN_LINES)) u_loss (
    .clk      (clk),
    .rst      (rst),
    .det      (det),
    .line_stb (line_stb),
    .tol3     (tol3),
    .lost     (vs_lost),
    .reacq    (pll_reacq)
  );
endmodule

// File: rtl/vsfd_chk.sv
module vsfd_chk #(
  parameter int HW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          sync_n,
  input logic [HW-1:0] hpos,
  input logic [HW-1:0] half_pos,
  input logic          vsync,
  input logic          field,
  input logic          vs_lost,
  input logic          pll_reacq
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!vsync && !field && !vs_lost && !pll_reacq)); // R10

  AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> !$past(sync_n, 2)); // R1

  AST_PARITY_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> (field == ($past(hpos) >= $past(half_pos)))); // R3

  AST_LOST_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> !vs_lost); // R9

  AST_REACQ_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_lost) |-> pll_reacq); // R8

  AST_REACQ_ONLY_LOSS: assert property (@(posedge clk) disable iff (rst)
    pll_reacq |-> $rose(vs_lost)); // R8

  AST_REACQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pll_reacq |=> !pll_reacq); // R8
endmodule

bind vsfd_top vsfd_chk #(.HW(HW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sync_n    (sync_n),
  .hpos      (hpos),
  .half_pos  (half_pos),
  .vsync     (vsync),
  .field     (field),
  .vs_lost   (vs_lost),
  .pll_reacq (pll_reacq)
);

// File: tb/sim_vsfd_top.sv
module sim_vsfd_top;
  localparam int HW = 10;
  localparam int CW = 10;
  localparam int LINE = 32;
  localparam int THR = 10;
  localparam int WIN = 337;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sync_n = 1'b1;
  logic          line_stb = 1'b0;
  logic [HW-1:0] hpos = '0;
  logic [CW-1:0] vthresh = CW'(THR);
  logic [HW-1:0] half_pos = HW'(LINE / 2);
  logic          tol3 = 1'b0;
  logic          std625 = 1'b0;
  logic          vsync, field, vs_lost, pll_reacq;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vsfd_top #(.HW(HW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .sync_n(sync_n), .line_stb(line_stb),
    .hpos(hpos), .vthresh(vthresh), .half_pos(half_pos),
    .tol3(tol3), .std625(std625), .vsync(vsync), .field(field),
    .vs_lost(vs_lost), .pll_reacq(pll_reacq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_low, m_hold, m_lines, m_win, m_miss;
  bit m_armed, m_vs, m_field, m_seen, m_lost, m_reacq;

  always @(posedge clk) begin
    bit ex, dt, wend, wmiss, decl;
    int need, last;
    if (rst) begin
      m_low = 0; m_hold = 0; m_lines = 0; m_win = 0; m_miss = 0;
      m_armed = 1; m_vs = 0; m_field = 0; m_seen = 0; m_lost = 0; m_reacq = 0;
    end else begin
      ex = (m_low > int'(vthresh));
      dt = m_armed && ex;
      need = tol3 ? 3 : 1;
      last = std625 ? 313 : 263;
      wend = line_stb && (m_win == WIN - 1);
      wmiss = wend && !m_seen && !dt;
      decl = wmiss && ((m_miss + 1) >= need);
      m_reacq = decl && !m_lost;
      if (dt) begin m_miss = 0; m_lost = 0; end
      else if (wmiss) begin
        if (m_miss < 3) m_miss = m_miss + 1;
        if (decl) m_lost = 1;
      end else if (wend) m_miss = 0;
      if (wend) m_seen = 0; else if (dt) m_seen = 1;
      if (line_stb) m_win = wend ? 0 : m_win + 1;
      if (dt) begin
        m_vs = 1; m_field = (int'(hpos) >= int'(half_pos));
        m_armed = 0; m_hold = 0; m_lines = 0;
      end else begin
        if (m_vs && line_stb) begin
          if (m_hold == 2) m_vs = 0; else m_hold = m_hold + 1;
        end else if (!m_vs && !ex) m_armed = 1;
        if (!m_vs && !ex) m_armed = 1;
        if (line_stb) begin
          if (m_lines + 1 >= last) begin m_lines = 0; m_field = !m_field; end
          else m_lines = m_lines + 1;
        end
      end
      m_low = sync_n ? 0 : ((m_low < 1023) ? m_low + 1 : m_low);
    end
  end

  // per-clock comparison and event counters
  int rises = 0, toggles = 0, pulses = 0;
  bit p_vs = 0, p_fld = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(vsync === m_vs, "R1", "vsync vs model", int'(vsync), int'(m_vs));
      chk(field === m_field, "R3", "field vs model", int'(field), int'(m_field));
      chk(vs_lost === m_lost, "R7", "vs_lost vs model", int'(vs_lost), int'(m_lost));
      chk(pll_reacq === m_reacq, "R8", "pll_reacq vs model", int'(pll_reacq), int'(m_reacq));
      if (vsync && !p_vs) rises++;
      if (field != p_fld) toggles++;
      if (pll_reacq) pulses++;
    end
    p_vs = vsync;
    p_fld = field;
  end

  task automatic run_line(input int s, input int len);
    for (int i = 0; i < LINE; i++) begin
      @(negedge clk);
      hpos = HW'(i);
      line_stb = (i == 0);
      sync_n = !((i < 3) || (len > 0 && i >= s && i < s + len));
    end
  endtask

  task automatic run_lines(input int n);
    for (int k = 0; k < n; k++) run_line(0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!vsync && !field && !vs_lost && !pll_reacq, "R10", "reset outputs",
        int'({vsync, field, vs_lost, pll_reacq}), 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    run_lines(3);
    run_line(4, 10);
    chk(rises == 0, "R2", "low run equal to threshold", rises, 0);
    run_line(4, THR + 1);
    chk(rises == 1, "R1", "low run one above threshold", rises, 1);
    chk(field == 1'b0, "R3", "first-half detection odd", int'(field), 0);
    run_line(4, 14);
    run_line(4, 14);
    chk(vsync == 1'b1, "R4", "vsync held through two strobes", int'(vsync), 1);
    chk(rises == 1, "R5", "no re-trigger while held", rises, 1);
    run_line(17, 13);
    chk(rises == 2, "R5", "re-armed after release", rises, 2);
    chk(field == 1'b1, "R3", "second-half detection even", int'(field), 1);
    run_lines(3);
    chk(vsync == 1'b0, "R4", "vsync released after three strobes", int'(vsync), 0);
    toggles = 0;
    run_lines(600);
    chk(toggles == 2, "R6", "free-run toggles at 263 lines", toggles, 2);
    run_lines(200);
    chk(vs_lost == 1'b1, "R7", "loss after one missing window", int'(vs_lost), 1);
    chk(pulses == 1, "R8", "one reacquire pulse", pulses, 1);
    run_lines(400);
    chk(pulses == 1, "R8", "no repeat pulse while lost", pulses, 1);
    run_line(4, THR + 1);
    chk(vs_lost == 1'b0, "R9", "detection clears loss", int'(vs_lost), 0);
    tol3 = 1'b1;
    run_lines(2 * WIN);
    chk(vs_lost == 1'b0, "R7", "three-window tolerance not yet met", int'(vs_lost), 0);
    run_lines(2 * WIN);
    chk(vs_lost == 1'b1, "R7", "loss after three missing windows", int'(vs_lost), 1);
    chk(pulses == 2, "R8", "second reacquire pulse", pulses, 2);
    std625 = 1'b1;
    run_line(4, THR + 1);
    toggles = 0;
    run_lines(400);
    chk(toggles == 1, "R6", "free-run toggles at 313 lines", toggles, 1);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
    if (!done) chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule